// File: doc/BRIEF.md
# Two-Digit Two-Base Logarithmic Multiplier

This block multiplies two operands held in a two-dimensional logarithmic form. In this form a value is a signed sum of terms, each of which is 2 raised to one exponent times a fixed real base D raised to a second exponent. The value of D does not change the hardware. Each operand has two such digits. A digit is stored as a sign bit, a zero flag, a two's-complement exponent of 2 and a two's-complement exponent of D.

Multiplying two digits takes only an XOR of the signs and two independent exponent additions. The block does this for all four pairings of operand digits at once and returns a four-digit result. It does not add those digits back together; that is left to a later stage.

A mode input turns the block into a single-digit divider. In that mode it subtracts digit 0 of the divisor from digit 0 of the dividend, and only result digit 0 is marked as meaningful. A parameter chooses whether the result goes through one register stage or leaves combinationally. The default exponent widths (6 bits and 5 bits) suit 16-bit data; 11 and 9 bits suit 32-bit data.

Top module: `dlog2_mul`

## Requirements
- R1: For each output digit that is valid and not zero, the sign bit equals the XOR of the two factor signs, where 0 means positive and 1 means negative.
- R2: With mode = 0 (multiply), each output exponent equals the sum of the factors' matching exponents. Sums are two's complement and one bit wider than the inputs, so they never overflow.
- R3: With mode = 1 (divide), output digit 0 carries the dividend exponents minus the divisor exponents (x minus y), one bit wider, in two's complement.
- R4: Output digit k pairs x digit k>>1 with y digit k&1, giving the order (x0·y0, x0·y1, x1·y0, x1·y1). Input digit i sits in bus slice i of each field, and output digit k sits in bus slice k.
- R5: An output digit's zero flag is the OR of its factors' zero flags. When the flag is set, that digit's sign and both exponents are 0.
- R6: While out_valid is 1, out_dv is 4'b1111 in multiply mode and 4'b0001 in divide mode. A digit with out_dv clear has all of its fields at 0.
- R7: While out_valid is 0, out_dv is 4'b0000.
- R8: With OUT_REG = 1, the outputs show the result of the inputs present at the previous rising clock edge. With OUT_REG = 0, they follow the current inputs in the same cycle.
- R9: While rst is high, the registered variant holds out_valid and out_dv at 0, whatever in_valid is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present |
| mode | input | 1 | 0 = multiply, 1 = single-digit divide |
| x_sign | input | 2 | Sign of each x digit |
| x_zero | input | 2 | Zero flag of each x digit |
| x_ea | input | 2*EA_W | Base-2 exponent of each x digit |
| x_eb | input | 2*EB_W | Base-D exponent of each x digit |
| y_sign | input | 2 | Sign of each y digit |
| y_zero | input | 2 | Zero flag of each y digit |
| y_ea | input | 2*EA_W | Base-2 exponent of each y digit |
| y_eb | input | 2*EB_W | Base-D exponent of each y digit |
| out_valid | output | 1 | Result is present |
| out_dv | output | 4 | Per-digit valid mask |
| out_sign | output | 4 | Sign of each result digit |
| out_zero | output | 4 | Zero flag of each result digit |
| out_ea | output | 4*(EA_W+1) | Base-2 exponent of each result digit |
| out_eb | output | 4*(EB_W+1) | Base-D exponent of each result digit |

## Verification
The bench runs on a 3-bit / 2-bit exponent configuration. It sweeps every combination of digit 0 of both operands in both modes, while the second digits vary and in_valid drops in a fixed pattern.

The sweep reaches the extreme exponent pairs. An adder that dropped the extension bit would wrap these into the wrong sign. A divider that swapped its operands would negate every result. The sweep also covers zero factors, so a design that left the exponents unmasked would leak nonzero fields. Wrong digit pairing would shuffle digits 1 and 2. A divide mode that did not clear digits 1 to 3 would leave them marked valid or carrying stale data.

Both the registered and the combinational variants are checked in their own cycle alignment, so an extra or a missing stage shows up at once.

// File: rtl/dlog2_pkg.sv
package dlog2_pkg;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } op_e;

    localparam int N_IN_DIG  = 2;
    localparam int N_OUT_DIG = N_IN_DIG * N_IN_DIG;

    // Output digit k takes x digit (k / N_IN_DIG) and y digit (k % N_IN_DIG).
    function automatic int x_of(input int k);
        return k / N_IN_DIG;
    endfunction

    function automatic int y_of(input int k);
        return k % N_IN_DIG;
    endfunction

    // Digits that carry meaning for a given operation.
    function automatic logic [N_OUT_DIG-1:0] dig_mask(input op_e op);
        logic [N_OUT_DIG-1:0] m;
        if (op == OP_DIV) begin
            m = '0;
            m[0] = 1'b1;
        end else begin
            m = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dlog2_exp_addsub.sv
module dlog2_exp_addsub #(
    parameter int W = 6
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W:0]   r
);

    logic signed [W:0] a_x;
    logic signed [W:0] b_x;

    always_comb begin
        a_x = $signed({a[W-1], a});
        b_x = $signed({b[W-1], b});
        if (sub) begin
            r = a_x - b_x;
        end else begin
            r = a_x + b_x;
        end
    end

endmodule

// File: rtl/dlog2_digit_op.sv
module dlog2_digit_op
    import dlog2_pkg::*;
#(
    parameter int EA_W = 6,
    parameter int EB_W = 5
) (
    input  op_e           op,
    input  logic          en,
    input  logic          xs,
    input  logic          xz,
    input  logic [EA_W-1:0] xa,
    input  logic [EB_W-1:0] xb,
    input  logic          ys,
    input  logic          yz,
    input  logic [EA_W-1:0] ya,
    input  logic [EB_W-1:0] yb,
    output logic          ps,
    output logic          pz,
    output logic [EA_W:0] pa,
    output logic [EB_W:0] pb
);

    logic [EA_W:0] sum_a;
    logic [EB_W:0] sum_b;
    logic          sub;

    assign sub = (op == OP_DIV);

    dlog2_exp_addsub #(.W(EA_W)) u_add_a (
        .a   (xa),
        .b   (ya),
        .sub (sub),
        .r   (sum_a)
    );

    dlog2_exp_addsub #(.W(EB_W)) u_add_b (
        .a   (xb),
        .b   (yb),
        .sub (sub),
        .r   (sum_b)
    );

    always_comb begin
        if (!en) begin
            ps = 1'b0;
            pz = 1'b0;
            pa = '0;
            pb = '0;
        end else if (xz || yz) begin
            ps = 1'b0;
            pz = 1'b1;
            pa = '0;
            pb = '0;
        end else begin
            ps = xs ^ ys;
            pz = 1'b0;
            pa = sum_a;
            pb = sum_b;
        end
    end

endmodule

// File: rtl/dlog2_out_stage.sv
module dlog2_out_stage #(
    parameter int W      = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         d_valid,
    input  logic [W-1:0] d_data,
    output logic         q_valid,
    output logic [W-1:0] q_data
);

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_valid <= 1'b0;
                    q_data  <= '0;
                end else begin
                    q_valid <= d_valid;
                    q_data  <= d_data;
                end
            end
        end else begin : g_comb
            assign q_valid = d_valid;
            assign q_data  = d_data;
        end
    endgenerate

endmodule

// File: rtl/dlog2_mul.sv
module dlog2_mul
    import dlog2_pkg::*;
#(
    parameter int EA_W    = 6,
    parameter int EB_W    = 5,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic                          mode,
    input  logic [N_IN_DIG-1:0]           x_sign,
    input  logic [N_IN_DIG-1:0]           x_zero,
    input  logic [N_IN_DIG*EA_W-1:0]      x_ea,
    input  logic [N_IN_DIG*EB_W-1:0]      x_eb,
    input  logic [N_IN_DIG-1:0]           y_sign,
    input  logic [N_IN_DIG-1:0]           y_zero,
    input  logic [N_IN_DIG*EA_W-1:0]      y_ea,
    input  logic [N_IN_DIG*EB_W-1:0]      y_eb,
    output logic                          out_valid,
    output logic [N_OUT_DIG-1:0]          out_dv,
    output logic [N_OUT_DIG-1:0]          out_sign,
    output logic [N_OUT_DIG-1:0]          out_zero,
    output logic [N_OUT_DIG*(EA_W+1)-1:0] out_ea,
    output logic [N_OUT_DIG*(EB_W+1)-1:0] out_eb
);

    localparam int EAO   = EA_W + 1;
    localparam int EBO   = EB_W + 1;
    localparam int A_BUS = N_OUT_DIG * EAO;
    localparam int B_BUS = N_OUT_DIG * EBO;
    localparam int DW    = 3 * N_OUT_DIG + A_BUS + B_BUS;

    op_e                  op;
    logic [N_OUT_DIG-1:0] mask;
    logic [N_OUT_DIG-1:0] c_dv;
    logic [N_OUT_DIG-1:0] c_sign;
    logic [N_OUT_DIG-1:0] c_zero;
    logic [A_BUS-1:0]     c_ea;
    logic [B_BUS-1:0]     c_eb;
    logic [DW-1:0]        c_data;
    logic [DW-1:0]        q_data;

    assign op   = op_e'(mode);
    assign mask = dig_mask(op);
    assign c_dv = in_valid ? mask : '0;

    generate
        for (genvar k = 0; k < N_OUT_DIG; k++) begin : g_dig
            localparam int XI = x_of(k);
            localparam int YI = y_of(k);

            dlog2_digit_op #(
                .EA_W (EA_W),
                .EB_W (EB_W)
            ) u_dig (
                .op (op),
                .en (mask[k]),
                .xs (x_sign[XI]),
                .xz (x_zero[XI]),
                .xa (x_ea[XI*EA_W +: EA_W]),
                .xb (x_eb[XI*EB_W +: EB_W]),
                .ys (y_sign[YI]),
                .yz (y_zero[YI]),
                .ya (y_ea[YI*EA_W +: EA_W]),
                .yb (y_eb[YI*EB_W +: EB_W]),
                .ps (c_sign[k]),
                .pz (c_zero[k]),
                .pa (c_ea[k*EAO +: EAO]),
                .pb (c_eb[k*EBO +: EBO])
            );
        end
    endgenerate

    assign c_data = {c_dv, c_sign, c_zero, c_ea, c_eb};

    dlog2_out_stage #(
        .W       (DW),
        .OUT_REG (OUT_REG)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .d_valid (in_valid),
        .d_data  (c_data),
        .q_valid (out_valid),
        .q_data  (q_data)
    );

    assign {out_dv, out_sign, out_zero, out_ea, out_eb} = q_data;

endmodule

// File: rtl/dlog2_mul_chk.sv
module dlog2_mul_chk
    import dlog2_pkg::*;
#(
    parameter int EA_W    = 6,
    parameter int EB_W    = 5,
    parameter bit OUT_REG = 1'b1
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic                          mode,
    input logic [N_IN_DIG-1:0]           x_sign,
    input logic [N_IN_DIG-1:0]           x_zero,
    input logic [N_IN_DIG*EA_W-1:0]      x_ea,
    input logic [N_IN_DIG*EB_W-1:0]      x_eb,
    input logic [N_IN_DIG-1:0]           y_sign,
    input logic [N_IN_DIG-1:0]           y_zero,
    input logic [N_IN_DIG*EA_W-1:0]      y_ea,
    input logic [N_IN_DIG*EB_W-1:0]      y_eb,
    input logic                          out_valid,
    input logic [N_OUT_DIG-1:0]          out_dv,
    input logic [N_OUT_DIG-1:0]          out_sign,
    input logic [N_OUT_DIG-1:0]          out_zero,
    input logic [N_OUT_DIG*(EA_W+1)-1:0] out_ea,
    input logic [N_OUT_DIG*(EB_W+1)-1:0] out_eb
);

    localparam int EAO = EA_W + 1;
    localparam int EBO = EB_W + 1;
    localparam int IW  = 2 + 2 * N_IN_DIG * (2 + EA_W + EB_W);

    // Inputs aligned to the cycle in which their result appears.
    logic [IW-1:0] in_now;
    logic [IW-1:0] in_ref;
    logic          r_valid;
    logic          r_mode;
    logic [N_IN_DIG-1:0]      r_xs, r_xz, r_ys, r_yz;
    logic [N_IN_DIG*EA_W-1:0] r_xa, r_ya;
    logic [N_IN_DIG*EB_W-1:0] r_xb, r_yb;

    assign in_now = {in_valid, mode, x_sign, x_zero, x_ea, x_eb,
                     y_sign, y_zero, y_ea, y_eb};

    generate
        if (OUT_REG) begin : g_ref_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    in_ref <= '0;
                end else begin
                    in_ref <= in_now;
                end
            end
        end else begin : g_ref_comb
            assign in_ref = in_now;
        end
    endgenerate

    assign {r_valid, r_mode, r_xs, r_xz, r_xa, r_xb,
            r_ys, r_yz, r_ya, r_yb} = in_ref;

    AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (rst)
        out_valid == r_valid) else $error("valid alignment"); // R8

    AST_IDLE_NO_DIGITS: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_dv == '0) else $error("digits while idle"); // R7

    AST_DIGIT_SET: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_dv == (r_mode ? 4'b0001 : 4'b1111)))
        else $error("digit mask"); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        (OUT_REG && $past(rst)) |-> (!out_valid && out_dv == '0))
        else $error("output during reset"); // R9

    generate
        for (genvar k = 0; k < N_OUT_DIG; k++) begin : g_k
            localparam int XI = x_of(k);
            localparam int YI = y_of(k);
            logic signed [EAO-1:0] xa_e, ya_e, ea_exp;
            logic signed [EBO-1:0] xb_e, yb_e, eb_exp;
            logic                  live;

            assign xa_e   = $signed({r_xa[XI*EA_W+EA_W-1], r_xa[XI*EA_W +: EA_W]});
            assign ya_e   = $signed({r_ya[YI*EA_W+EA_W-1], r_ya[YI*EA_W +: EA_W]});
            assign xb_e   = $signed({r_xb[XI*EB_W+EB_W-1], r_xb[XI*EB_W +: EB_W]});
            assign yb_e   = $signed({r_yb[YI*EB_W+EB_W-1], r_yb[YI*EB_W +: EB_W]});
            assign ea_exp = r_mode ? (xa_e - ya_e) : (xa_e + ya_e);
            assign eb_exp = r_mode ? (xb_e - yb_e) : (xb_e + yb_e);
            assign live   = out_dv[k] && !r_xz[XI] && !r_yz[YI];

            AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
                live |-> out_sign[k] == (r_xs[XI] ^ r_ys[YI]))
                else $error("sign"); // R1

            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
                (live && !r_mode) |-> ($signed(out_ea[k*EAO +: EAO]) == ea_exp
                                       && $signed(out_eb[k*EBO +: EBO]) == eb_exp))
                else $error("product exponent"); // R2

            AST_DIV_DIFF: assert property (@(posedge clk) disable iff (rst)
                (live && r_mode) |-> ($signed(out_ea[k*EAO +: EAO]) == ea_exp
                                      && $signed(out_eb[k*EBO +: EBO]) == eb_exp))
                else $error("quotient exponent"); // R3

            AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (out_dv[k] && out_zero[k]) |->
                    (!out_sign[k] && out_ea[k*EAO +: EAO] == '0
                     && out_eb[k*EBO +: EBO] == '0))
                else $error("zero digit fields"); // R5

            AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
                out_dv[k] |-> out_zero[k] == (r_xz[XI] | r_yz[YI]))
                else $error("zero flag"); // R5

            AST_IDLE_DIGIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
                (out_valid && !out_dv[k]) |->
                    (!out_sign[k] && !out_zero[k] && out_ea[k*EAO +: EAO] == '0
                     && out_eb[k*EBO +: EBO] == '0))
                else $error("unused digit not cleared"); // R6
        end
    endgenerate

endmodule

bind dlog2_mul dlog2_mul_chk #(
    .EA_W    (EA_W),
    .EB_W    (EB_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode      (mode),
    .x_sign    (x_sign),
    .x_zero    (x_zero),
    .x_ea      (x_ea),
    .x_eb      (x_eb),
    .y_sign    (y_sign),
    .y_zero    (y_zero),
    .y_ea      (y_ea),
    .y_eb      (y_eb),
    .out_valid (out_valid),
    .out_dv    (out_dv),
    .out_sign  (out_sign),
    .out_zero  (out_zero),
    .out_ea    (out_ea),
    .out_eb    (out_eb)
);

// File: tb/dlog2_mul_bench.sv
module dlog2_mul_bench;

    localparam int EA  = 3;
    localparam int EB  = 2;
    localparam int EAO = EA + 1;
    localparam int EBO = EB + 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            mode = 1'b0;
    logic [1:0]      x_sign = '0, x_zero = '0, y_sign = '0, y_zero = '0;
    logic [2*EA-1:0] x_ea = '0, y_ea = '0;
    logic [2*EB-1:0] x_eb = '0, y_eb = '0;

    logic            rv, cv;
    logic [3:0]      r_dv, r_s, r_z, c_dv, c_s, c_z;
    logic [4*EAO-1:0] r_ea, c_ea;
    logic [4*EBO-1:0] r_eb, c_eb;

    int n_chk  = 0;
    int n_fail = 0;

    // Expected result for the present inputs, and for the previous ones.
    logic            e_v, p_v, p_mode;
    logic [3:0]      e_dv, e_s, e_z, p_dv, p_s, p_z;
    logic [4*EAO-1:0] e_ea, p_ea;
    logic [4*EBO-1:0] e_eb, p_eb;

    always #10 clk = ~clk;

    dlog2_mul #(.EA_W(EA), .EB_W(EB), .OUT_REG(1'b1)) u_dlog2_mul (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .x_sign(x_sign), .x_zero(x_zero), .x_ea(x_ea), .x_eb(x_eb),
        .y_sign(y_sign), .y_zero(y_zero), .y_ea(y_ea), .y_eb(y_eb),
        .out_valid(rv), .out_dv(r_dv), .out_sign(r_s), .out_zero(r_z),
        .out_ea(r_ea), .out_eb(r_eb)
    );

    dlog2_mul #(.EA_W(EA), .EB_W(EB), .OUT_REG(1'b0)) u_dlog2_mul_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .x_sign(x_sign), .x_zero(x_zero), .x_ea(x_ea), .x_eb(x_eb),
        .y_sign(y_sign), .y_zero(y_zero), .y_ea(y_ea), .y_eb(y_eb),
        .out_valid(cv), .out_dv(c_dv), .out_sign(c_s), .out_zero(c_z),
        .out_ea(c_ea), .out_eb(c_eb)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Reference arithmetic from the requirements.
    task automatic model();
        e_v  = in_valid;
        e_dv = in_valid ? (mode ? 4'b0001 : 4'b1111) : 4'b0000;   // R6 R7
        e_s = '0; e_z = '0; e_ea = '0; e_eb = '0;
        for (int k = 0; k < 4; k++) begin
            int xi, yi, xa, ya, xb, yb, ra, rb;
            xi = k / 2;                                           // R4
            yi = k % 2;
            if (mode && k != 0) continue;
            xa = int'($signed(x_ea[xi*EA +: EA]));
            ya = int'($signed(y_ea[yi*EA +: EA]));
            xb = int'($signed(x_eb[xi*EB +: EB]));
            yb = int'($signed(y_eb[yi*EB +: EB]));
            ra = mode ? xa - ya : xa + ya;                        // R2 R3
            rb = mode ? xb - yb : xb + yb;
            if (x_zero[xi] || y_zero[yi]) begin                   // R5
                e_z[k] = 1'b1;
            end else begin
                e_s[k] = x_sign[xi] ^ y_sign[yi];                 // R1
                e_ea[k*EAO +: EAO] = EAO'(ra);
                e_eb[k*EBO +: EBO] = EBO'(rb);
            end
        end
    endtask

    task automatic cmp(input string who, input logic md,
                       input logic ev, input logic [3:0] edv, input logic [3:0] es,
                       input logic [3:0] ez, input logic [4*EAO-1:0] ea,
                       input logic [4*EBO-1:0] eb,
                       input logic gv, input logic [3:0] gdv, input logic [3:0] gs,
                       input logic [3:0] gz, input logic [4*EAO-1:0] ga,
                       input logic [4*EBO-1:0] gb);
        chk({who, " R8 R7 valid/mask"}, {59'd0, gv, gdv}, {59'd0, ev, edv});
        if (ev) begin
            chk({who, " R6 mask"}, {60'd0, gdv}, {60'd0, edv});
            chk({who, " R1 sign"}, {60'd0, gs}, {60'd0, es});
            chk({who, " R5 zero"}, {60'd0, gz}, {60'd0, ez});
            chk({who, md ? " R3 exp2" : " R2 R4 exp2"}, 64'(ga), 64'(ea));
            chk({who, md ? " R3 expD" : " R2 R4 expD"}, 64'(gb), 64'(eb));
        end
    endtask

    logic done = 1'b0;

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: busy inputs during reset must not reach the registered outputs.
        @(negedge clk);
        in_valid = 1'b1;
        x_ea = 6'h2d; y_ea = 6'h13;
        repeat (3) begin
            @(negedge clk);
            chk("R9 reset valid/mask", {59'd0, rv, r_dv}, 64'd0);
        end
        in_valid = 1'b0;
        rst = 1'b0;
        model();
        p_v = e_v; p_dv = e_dv; p_s = e_s; p_z = e_z; p_ea = e_ea; p_eb = e_eb;
        p_mode = mode;

        for (int n = 0; n < 32768; n++) begin
            logic [13:0] v;
            logic [13:0] h;
            @(negedge clk);
            cmp("reg", p_mode, p_v, p_dv, p_s, p_z, p_ea, p_eb,
                rv, r_dv, r_s, r_z, r_ea, r_eb);
            v = n[13:0];
            h = 14'(n * 37 + 11) ^ 14'(n >> 3);
            mode      = n[14];
            in_valid  = (n % 7) != 6;
            x_eb[EB-1:0] = v[1:0];  x_ea[EA-1:0] = v[4:2];
            x_zero[0] = v[5];       x_sign[0] = v[6];
            y_eb[EB-1:0] = v[8:7];  y_ea[EA-1:0] = v[11:9];
            y_zero[0] = v[12];      y_sign[0] = v[13];
            x_eb[2*EB-1:EB] = h[1:0]; x_ea[2*EA-1:EA] = h[4:2];
            x_zero[1] = h[5] & h[6];  x_sign[1] = h[7];
            y_eb[2*EB-1:EB] = h[9:8]; y_ea[2*EA-1:EA] = h[12:10];
            y_zero[1] = h[13] & h[0]; y_sign[1] = h[11] ^ h[3];
            #1;
            model();
            cmp("comb", mode, e_v, e_dv, e_s, e_z, e_ea, e_eb,
                cv, c_dv, c_s, c_z, c_ea, c_eb);
            p_v = e_v; p_dv = e_dv; p_s = e_s; p_z = e_z; p_ea = e_ea; p_eb = e_eb;
            p_mode = mode;
        end
        @(negedge clk);
        cmp("reg", p_mode, p_v, p_dv, p_s, p_z, p_ea, p_eb,
            rv, r_dv, r_s, r_z, r_ea, r_eb);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule